// File: doc/BRIEF.md
# Bus-Side Memory Chip Select Subsystem

This block sits between a CPU bus (16-bit byte address, 8-bit data, active-low read and write strobes) and two memory regions: a 16 KB read-only region and an 8 KB read/write region. It compares the upper address bits with each region's assigned range and produces an active-low select for the matching device. It returns read data only from the device that was selected. It stores bytes into the read/write region when the write strobe is active. A build-time parameter chooses between a fully decoded map, where each address reaches at most one location, and a partially decoded map, which compares fewer address bits so that the RAM appears at several addresses and one range answers to nothing.

All outputs are registered. The address and strobes sampled at one rising clock edge produce the selects, flags and read byte that are visible until the next edge. The read-only contents are computed from the byte offset and a seed parameter, so no memory file is needed. The RAM is a single-port array with registered read data, which suits block RAM on an FPGA.

Top module: `memsel_subsys`

## Requirements
- R1: In both modes, a cycle with exactly one strobe low and A15 = A14 = 0 (0000H–3FFFH) drives `cs_rom_n` low in the cycle after the sampling edge, with `cs_ram_n` high.
- R2: A read from the ROM region returns the byte `off[7:0] ^ {2'b00, off[13:8]} ^ ROM_SEED`, where `off` is A13..A0 and `ROM_SEED` defaults to 8'h5A.
- R3: With full decoding, the RAM is selected only for 4000H–5FFFH (A15..A13 = 010). Every address outside the ROM and RAM ranges is unmapped.
- R4: With partial decoding, the RAM is selected whenever A14 = 1, using the offset A12..A0. It therefore answers at 4000H–7FFFH and C000H–FFFFH. The range 8000H–BFFFH is unmapped.
- R5: A cycle with `wr_n` low and `rd_n` high at a RAM address stores `wr_data` at that offset on the clock edge, and a later read of any address that reaches that offset returns the stored byte.
- R6: A write to a ROM address or an unmapped address changes no storage.
- R7: A read from an unmapped address gives `rd_data` = FFH and raises `unmapped`, with both selects high.
- R8: When `rd_n` and `wr_n` are both low, the next cycle shows `bus_err` = 1, both selects high, `rd_data` = FFH, and nothing is written.
- R9: When both strobes are high, the next cycle shows both selects high, `unmapped` and `bus_err` low, and `rd_data` = FFH. At most one select is ever low.
- R10: While `rst` is high at a clock edge, the following cycle shows both selects high, both flags low and `rd_data` = FFH, whatever the strobes are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | CPU byte address |
| wr_data | input | 8 | Byte to store on a write |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cs_rom_n | output | 1 | ROM region select, active low, registered |
| cs_ram_n | output | 1 | RAM region select, active low, registered |
| rd_data | output | 8 | Read byte from the selected device, FFH otherwise |
| unmapped | output | 1 | Read of an address that no device decodes |
| bus_err | output | 1 | Both strobes were low together |

## Verification
The properties assume that the address and both strobes are stable around each rising edge, and that reset is high at the first edge so that every registered output starts from its cleared value. Both strobes low at once is a legal but flagged input, and the properties check it rather than exclude it. The bench changes every input on the falling edge and draws strobe patterns at random, including idle and both-low cycles. It drives one stimulus stream into a fully decoded instance and a partially decoded instance, so the same address exposes aliasing in one and unmapped behaviour in the other.

// File: rtl/memsel_pkg.sv
package memsel_pkg;
  typedef enum logic [1:0] {
    DEV_NONE = 2'd0,
    DEV_ROM  = 2'd1,
    DEV_RAM  = 2'd2
  } dev_t;
endpackage

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              ROM_AW      = 14,
  parameter int              RAM_AW      = 13,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'h4000,
  parameter bit              FULL_DECODE = 1'b1,
  parameter int              PART_BIT    = 14
) (
  input  logic [ADDR_W-1:RAM_AW] addr_hi,
  output dev_t                   sel
);
  localparam logic [ADDR_W-1:RAM_AW] RAM_TAG = RAM_BASE[ADDR_W-1:RAM_AW];

  logic rom_hit;
  logic ram_hit;

  // ROM region compares every line above its internal offset in both modes
  assign rom_hit = (addr_hi[ADDR_W-1:ROM_AW] == '0);

  generate
    if (FULL_DECODE) begin : g_full
      assign ram_hit = (addr_hi == RAM_TAG);
    end else begin : g_part
      assign ram_hit = addr_hi[PART_BIT];
    end
  endgenerate

  always_comb begin
    if (rom_hit)      sel = DEV_ROM;
    else if (ram_hit) sel = DEV_RAM;
    else              sel = DEV_NONE;
  end
endmodule

// File: rtl/memsel_rom.sv
module memsel_rom #(
  parameter int               AW   = 14,
  parameter int               DW   = 8,
  parameter logic [DW-1:0]    SEED = 8'h5A
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] off,
  output logic [DW-1:0] q
);
  function automatic logic [DW-1:0] rom_byte(input logic [AW-1:0] o);
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    lo = DW'(o);
    hi = DW'(o >> DW);
    return lo ^ hi ^ SEED;
  endfunction

  always_ff @(posedge clk) begin
    if (en) q <= rom_byte(off);
  end
endmodule

// File: rtl/memsel_ram.sv
module memsel_ram #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/memsel_subsys.sv
module memsel_subsys
  import memsel_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                ROM_AW      = 14,
  parameter int                RAM_AW      = 13,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 16'h4000,
  parameter bit                FULL_DECODE = 1'b1,
  parameter int                PART_BIT    = 14,
  parameter logic [DATA_W-1:0] ROM_SEED    = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              cs_rom_n,
  output logic              cs_ram_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              unmapped,
  output logic              bus_err
);
  dev_t sel;
  dev_t rsel_q;
  logic rd_act, wr_act, both_act, any_act;
  logic rom_en, ram_en;
  logic [DATA_W-1:0] rom_q, ram_q;

  assign rd_act   = !rd_n &&  wr_n;
  assign wr_act   =  rd_n && !wr_n;
  assign both_act = !rd_n && !wr_n;
  assign any_act  = rd_act || wr_act;

  memsel_decoder #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW),
    .RAM_BASE(RAM_BASE), .FULL_DECODE(FULL_DECODE), .PART_BIT(PART_BIT)
  ) u_dec (
    .addr_hi (addr[ADDR_W-1:RAM_AW]),
    .sel     (sel)
  );

  assign rom_en = !rst && rd_act  && (sel == DEV_ROM);
  assign ram_en = !rst && any_act && (sel == DEV_RAM);

  memsel_rom #(.AW(ROM_AW), .DW(DATA_W), .SEED(ROM_SEED)) u_rom (
    .clk (clk),
    .en  (rom_en),
    .off (addr[ROM_AW-1:0]),
    .q   (rom_q)
  );

  memsel_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (wr_act),
    .addr  (addr[RAM_AW-1:0]),
    .wdata (wr_data),
    .q     (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_rom_n <= 1'b1;
      cs_ram_n <= 1'b1;
      unmapped <= 1'b0;
      bus_err  <= 1'b0;
      rsel_q   <= DEV_NONE;
    end else begin
      cs_rom_n <= !(any_act && (sel == DEV_ROM));
      cs_ram_n <= !(any_act && (sel == DEV_RAM));
      unmapped <= rd_act && (sel == DEV_NONE);
      bus_err  <= both_act;
      rsel_q   <= rd_act ? sel : DEV_NONE;
    end
  end

  always_comb begin
    case (rsel_q)
      DEV_ROM: rd_data = rom_q;
      DEV_RAM: rd_data = ram_q;
      default: rd_data = '1;
    endcase
  end
endmodule

// File: rtl/memsel_checker.sv
module memsel_checker #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                ROM_AW      = 14,
  parameter int                RAM_AW      = 13,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 16'h4000,
  parameter bit                FULL_DECODE = 1'b1,
  parameter int                PART_BIT    = 14
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:RAM_AW]   addr_hi,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic                     cs_rom_n,
  input logic                     cs_ram_n,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     unmapped,
  input logic                     bus_err
);
  localparam logic [ADDR_W-1:RAM_AW] RAM_TAG = RAM_BASE[ADDR_W-1:RAM_AW];

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !(!cs_rom_n && !cs_ram_n)); // R9

  AST_ROM_DECODE: assert property (@(posedge clk) disable iff (rst)
    ((rd_n ^ wr_n) && addr_hi[ADDR_W-1:ROM_AW] == '0) |=> (!cs_rom_n && cs_ram_n)); // R1

  generate
    if (FULL_DECODE) begin : g_full
      AST_RAM_FULL_MAP: assert property (@(posedge clk) disable iff (rst)
        ((rd_n ^ wr_n) && addr_hi == RAM_TAG) |=> !cs_ram_n); // R3
    end else begin : g_part
      AST_RAM_ALIAS: assert property (@(posedge clk) disable iff (rst)
        ((rd_n ^ wr_n) && addr_hi[PART_BIT]) |=> !cs_ram_n); // R4
    end
  endgenerate

  AST_UNMAPPED_FLOAT: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (rd_data == '1 && cs_rom_n && cs_ram_n)); // R7

  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !wr_n) |=> (bus_err && cs_rom_n && cs_ram_n && rd_data == '1)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rd_n && wr_n) |=> (cs_rom_n && cs_ram_n && !unmapped && !bus_err && rd_data == '1)); // R9
endmodule

bind memsel_subsys memsel_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW),
  .RAM_BASE(RAM_BASE), .FULL_DECODE(FULL_DECODE), .PART_BIT(PART_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr_hi  (addr[ADDR_W-1:RAM_AW]),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .cs_rom_n (cs_rom_n),
  .cs_ram_n (cs_ram_n),
  .rd_data  (rd_data),
  .unmapped (unmapped),
  .bus_err  (bus_err)
);

// File: tb/memsel_subsys_bench.sv
module memsel_subsys_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wd = 8'h00;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;

  logic f_rom, f_ram, f_unm, f_err;
  logic p_rom, p_ram, p_unm, p_err;
  logic [7:0] f_dat, p_dat;

  logic [7:0] shf [8192];
  logic [7:0] shp [8192];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  memsel_subsys #(.FULL_DECODE(1'b1)) u_memsel_subsys (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wd), .rd_n(rd_n), .wr_n(wr_n),
    .cs_rom_n(f_rom), .cs_ram_n(f_ram), .rd_data(f_dat), .unmapped(f_unm), .bus_err(f_err)
  );

  memsel_subsys #(.FULL_DECODE(1'b0)) u_memsel_subsys_p (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wd), .rd_n(rd_n), .wr_n(wr_n),
    .cs_rom_n(p_rom), .cs_ram_n(p_ram), .rd_data(p_dat), .unmapped(p_unm), .bus_err(p_err)
  );

  // 0 none, 1 rom, 2 ram
  function automatic int dev_of(input logic [15:0] a, input bit full);
    if (a[15:14] == 2'b00) return 1;
    if (full) return (a[15:13] == 3'b010) ? 2 : 0;
    return a[14] ? 2 : 0;
  endfunction

  function automatic logic [7:0] rom_ref(input logic [13:0] o);
    return o[7:0] ^ {2'b00, o[13:8]} ^ 8'h5A;
  endfunction

  // {cs_rom_n, cs_ram_n, unmapped, bus_err, rd_data}
  function automatic logic [11:0] expect_out(input bit full, input logic [15:0] a,
                                             input logic rdn, input logic wrn);
    int d;
    logic [7:0] ram_b;
    d = dev_of(a, full);
    ram_b = full ? shf[a[12:0]] : shp[a[12:0]];
    if (!rdn && !wrn) return {4'b1101, 8'hFF};
    if (rdn && wrn)   return {4'b1100, 8'hFF};
    if (!rdn) begin
      if (d == 1) return {4'b0100, rom_ref(a[13:0])};
      if (d == 2) return {4'b1000, ram_b};
      return {4'b1110, 8'hFF};
    end
    if (d == 1) return {4'b0100, 8'hFF};
    if (d == 2) return {4'b1000, 8'hFF};
    return {4'b1100, 8'hFF};
  endfunction

  function automatic string auto_tag(input logic [15:0] a, input logic rdn, input logic wrn);
    int d;
    d = dev_of(a, 1'b1);
    if (!rdn && !wrn) return "R8";
    if (rdn && wrn)   return "R9";
    if (d == 0) return wrn ? "R7" : "R6";
    if (d == 1) return wrn ? "R2" : "R6";
    return "R5";
  endfunction

  task automatic check(input string req, input string who,
                       input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s addr=%h got=%h expected=%h", req, who, addr, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d,
                      input logic rdn, input logic wrn, input string req);
    logic [11:0] ef, ep;
    string tg;
    addr = a; wd = d; rd_n = rdn; wr_n = wrn;
    ef = expect_out(1'b1, a, rdn, wrn);
    ep = expect_out(1'b0, a, rdn, wrn);
    if (rdn && !wrn) begin
      if (dev_of(a, 1'b1) == 2) shf[a[12:0]] = d;
      if (dev_of(a, 1'b0) == 2) shp[a[12:0]] = d;
    end
    tg = (req == "") ? auto_tag(a, rdn, wrn) : req;
    @(posedge clk);
    @(negedge clk);
    check(tg, "full", {f_rom, f_ram, f_unm, f_err, f_dat}, ef);
    check(tg, "part", {p_rom, p_ram, p_unm, p_err, p_dat}, ep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    check("R10", "full", {f_rom, f_ram, f_unm, f_err, f_dat}, {4'b1100, 8'hFF});
    check("R10", "part", {p_rom, p_ram, p_unm, p_err, p_dat}, {4'b1100, 8'hFF});
    rst = 1'b0;

    // R5: fill every RAM offset through the window common to both modes
    for (int i = 0; i < 8192; i++)
      step(16'(16'h4000 + i), 8'(i) ^ 8'(i >> 8) ^ 8'h3C, 1'b1, 1'b0, "R5");

    // R1 / R2: ROM reads at both ends and inside
    step(16'h0000, 8'h00, 1'b0, 1'b1, "R1");
    step(16'h3FFF, 8'h00, 1'b0, 1'b1, "R2");
    step(16'h1234, 8'h00, 1'b0, 1'b1, "R2");
    // R3 / R4: range edges and aliases
    step(16'h5FFF, 8'h00, 1'b0, 1'b1, "R3");
    step(16'h6000, 8'h00, 1'b0, 1'b1, "R3");
    step(16'hC123, 8'h00, 1'b0, 1'b1, "R4");
    step(16'hFFFF, 8'h00, 1'b0, 1'b1, "R4");
    step(16'h8000, 8'h00, 1'b0, 1'b1, "R4");
    step(16'hA5A5, 8'h00, 1'b0, 1'b1, "R7");
    // R6: writes to ROM and to holes leave storage alone
    step(16'h0040, 8'h99, 1'b1, 1'b0, "R6");
    step(16'h0040, 8'h00, 1'b0, 1'b1, "R6");
    step(16'h9000, 8'h77, 1'b1, 1'b0, "R6");
    step(16'h5000, 8'h00, 1'b0, 1'b1, "R6");
    step(16'h6000, 8'hEE, 1'b1, 1'b0, "R6");
    step(16'h4000, 8'h00, 1'b0, 1'b1, "R6");
    // R8: both strobes, then confirm no write
    step(16'h4005, 8'h11, 1'b0, 1'b0, "R8");
    step(16'h4005, 8'h00, 1'b0, 1'b1, "R8");
    // R9: idle
    step(16'h4005, 8'h00, 1'b1, 1'b1, "R9");
    // R5: write then read back through an alias in partial mode
    step(16'h5ABC, 8'hC3, 1'b1, 1'b0, "R5");
    step(16'h5ABC, 8'h00, 1'b0, 1'b1, "R5");
    step(16'hFABC, 8'h00, 1'b0, 1'b1, "R4");
    // R10: reset mid-run with a read pending
    addr = 16'h0010; rd_n = 1'b0; wr_n = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10", "full", {f_rom, f_ram, f_unm, f_err, f_dat}, {4'b1100, 8'hFF});
    check("R10", "part", {p_rom, p_ram, p_unm, p_err, p_dat}, {4'b1100, 8'hFF});
    rst = 1'b0;

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [15:0] a;
      logic [7:0]  d;
      k = int'($urandom % 8);
      a = 16'($urandom);
      d = 8'($urandom);
      if (k < 4)       step(a, d, 1'b0, 1'b1, "");
      else if (k < 6)  step(a, d, 1'b1, 1'b0, "");
      else if (k == 6) step(a, d, 1'b1, 1'b1, "");
      else             step(a, d, 1'b0, 1'b0, "");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule